// File: doc/BRIEF.md
# Watchdog Reset Controller with Bus-Deferred Manual Reset

The block is a watchdog timer with a reset front end. A prescaler divides the system clock according to a 3-bit select field. The divided tick advances an up-counter. When the counter wraps, the outcome depends on the mode and on the control bits. In interval mode the block raises a flag and an interrupt request. In watchdog mode it pulses an active-low overflow pin. It then either issues a reset request or, with reset disabled, clears the timer and its control register.

A power-on type request is issued at once and does not depend on the bus. A manual type request first waits until the CPU owns an idle bus: the bus must not be busy, must not be handed to another master, and must not be in a DMA burst. If that wait reaches the fixed reset window, the request is dropped. Software writes the counter and the control register through a keyed write port.

The overflow pin is meant for board-level reset logic. It must not be routed back into this chip's own reset input.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: A write with `wr_sel_i`=0 loads the counter from the low data bits only when `wr_data_i[15:8]`=0x5A. A write with `wr_sel_i`=1 loads the control register only when `wr_data_i[15:8]`=0xA5. Any other write leaves both unchanged. Control bits: [7] overflow flag, [6] mode (1 watchdog, 0 interval), [5] timer enable, [4] reset enable, [3] reset type (1 manual, 0 power-on), [2:0] clock select. Writing 1 to the flag has no effect, and writing 0 clears it.
- R2: While enabled, the counter advances once every 2^(select*SHIFT_STEP) clocks. The first increment comes that many clocks after the enabling write. While the timer is disabled, the prescaler is held at zero and the counter holds its value.
- R3: On a watchdog-mode overflow with reset enable 0, the counter and the whole control register become 0, the prescaler restarts, and neither reset output is asserted.
- R4: On every watchdog-mode overflow, `ovf_n_o` is low for exactly PULSE_W cycles, starting the cycle after the overflow edge.
- R5: On an interval-mode overflow, the flag is set, `irq_o` follows the flag, and the counter wraps to 0 and keeps counting. `ovf_n_o` stays high and no reset is issued.
- R6: A power-on type overflow (reset enable 1, type 0) drives `por_rst_o` high for exactly RST_WIN cycles, starting the cycle after the overflow edge, whatever the bus inputs are.
- R7: A manual type overflow raises `mrst_o` only after a cycle in which `bus_busy_i`, `bus_rel_i` and `burst_i` are all 0. It then stays high for exactly RST_WIN cycles.
- R8: If the manual request has been blocked for fewer than RST_WIN cycles, it is still issued. If it has been blocked for RST_WIN cycles, it is discarded and `mrst_o` never rises for it.
- R9: A reset-issuing overflow sets the flag, clears the timer enable and returns the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 control |
| wr_data_i | input | 16 | Key in [15:8], value in [7:0] |
| bus_busy_i | input | 1 | A bus cycle is in progress |
| bus_rel_i | input | 1 | Bus is granted to another master |
| burst_i | input | 1 | DMA burst transfer active |
| cnt_o | output | CNT_W | Counter value |
| csr_o | output | 8 | Control register value |
| irq_o | output | 1 | Interval overflow interrupt request |
| ovf_n_o | output | 1 | Active-low watchdog overflow pin |
| por_rst_o | output | 1 | Power-on reset request |
| mrst_o | output | 1 | Manual reset request |

## Verification
The bench builds the block with CNT_W=4, SHIFT_STEP=1, PULSE_W=4 and RST_WIN=16. With these values an overflow comes two cycles after arming a preset counter. The whole reset window and both sides of the drop boundary, 15 and 16 blocked cycles, then fit in a few dozen cycles. With SHIFT_STEP=1 a nonzero clock select gives short exact tick periods, so the prescaler ratio and its restart can be checked cycle by cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CSR_OVF  = 7;
  localparam int CSR_WDM  = 6;
  localparam int CSR_TME  = 5;
  localparam int CSR_RSTE = 4;
  localparam int CSR_RTYP = 3;
  localparam int CKS_W    = 3;

  typedef enum logic [1:0] {
    MR_IDLE = 2'd0,
    MR_PEND = 2'd1,
    MR_ACT  = 2'd2
  } mr_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SHIFT_STEP = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     run_i,
  input  logic                     clr_i,
  input  logic [wdt_pkg::CKS_W-1:0] cks_i,
  output logic                     tick_o
);
  localparam int PRE_W = ((1 << wdt_pkg::CKS_W) - 1) * SHIFT_STEP;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = ~({PRE_W{1'b1}} << (int'(cks_i) * SHIFT_STEP));
  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i || !run_i) pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int         CNT_W   = 8,
  parameter logic [7:0] KEY_CNT = 8'h5A,
  parameter logic [7:0] KEY_CSR = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [15:0]      wr_data_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       csr_o,
  output logic             irq_o,
  output logic             wd_ovf_o,
  output logic             pre_clr_o,
  output logic             por_req_o,
  output logic             mrst_req_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       csr_q;
  logic             ovf_evt, wr_cnt, wr_csr, wd_rst;

  assign ovf_evt    = tick_i && (cnt_q == '1);
  assign wr_cnt     = wr_en_i && !wr_sel_i && (wr_data_i[15:8] == KEY_CNT);
  assign wr_csr     = wr_en_i &&  wr_sel_i && (wr_data_i[15:8] == KEY_CSR);
  assign wd_ovf_o   = ovf_evt && csr_q[CSR_WDM];
  assign wd_rst     = wd_ovf_o && csr_q[CSR_RSTE];
  assign pre_clr_o  = wd_ovf_o && !csr_q[CSR_RSTE];
  assign por_req_o  = wd_rst && !csr_q[CSR_RTYP];
  assign mrst_req_o = wd_rst &&  csr_q[CSR_RTYP];
  assign irq_o      = csr_q[CSR_OVF] && !csr_q[CSR_WDM];
  assign cnt_o      = cnt_q;
  assign csr_o      = csr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      csr_q <= '0;
    end else if (ovf_evt) begin
      cnt_q <= '0;
      if (!csr_q[CSR_WDM]) begin
        csr_q[CSR_OVF] <= 1'b1;
      end else if (!csr_q[CSR_RSTE]) begin
        csr_q <= '0;
      end else begin
        csr_q[CSR_OVF] <= 1'b1;
        csr_q[CSR_TME] <= 1'b0;
      end
    end else begin
      if (wr_cnt)      cnt_q <= wr_data_i[CNT_W-1:0];
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (wr_csr)
        csr_q <= {csr_q[CSR_OVF] & wr_data_i[CSR_OVF], wr_data_i[6:0]};
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       left_q <= '0;
    else if (start_i)  left_q <= LW'(LEN);
    else if (active_o) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdt_mrst_defer.sv
module wdt_mrst_defer #(
  parameter int RST_WIN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic blocked_i,
  output logic mrst_o
);
  import wdt_pkg::*;

  localparam int WIN_W = $clog2(RST_WIN);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(RST_WIN - 1);

  mr_state_e        st_q;
  logic [WIN_W-1:0] win_q;

  assign mrst_o = (st_q == MR_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MR_IDLE;
      win_q <= '0;
    end else begin
      unique case (st_q)
        MR_IDLE: if (req_i) begin
          st_q  <= MR_PEND;
          win_q <= '0;
        end
        MR_PEND: begin
          if (!blocked_i) begin
            st_q  <= MR_ACT;
            win_q <= '0;
          end else if (win_q == WIN_LAST) begin
            st_q  <= MR_IDLE;   // waited a full window: drop request
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        MR_ACT: begin
          if (win_q == WIN_LAST) st_q <= MR_IDLE;
          else                   win_q <= win_q + 1'b1;
        end
        default: st_q <= MR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl #(
  parameter int         CNT_W      = 8,
  parameter int         SHIFT_STEP = 2,
  parameter int         PULSE_W    = 128,
  parameter int         RST_WIN    = 512,
  parameter logic [7:0] KEY_CNT    = 8'h5A,
  parameter logic [7:0] KEY_CSR    = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [15:0]      wr_data_i,
  input  logic             bus_busy_i,
  input  logic             bus_rel_i,
  input  logic             burst_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       csr_o,
  output logic             irq_o,
  output logic             ovf_n_o,
  output logic             por_rst_o,
  output logic             mrst_o
);
  import wdt_pkg::*;

  logic tick, wd_ovf, pre_clr, por_req, mrst_req, pin_act;

  wdt_prescaler #(.SHIFT_STEP(SHIFT_STEP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (csr_o[CSR_TME]),
    .clr_i  (pre_clr),
    .cks_i  (csr_o[CKS_W-1:0]),
    .tick_o (tick)
  );

  wdt_core #(.CNT_W(CNT_W), .KEY_CNT(KEY_CNT), .KEY_CSR(KEY_CSR)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .tick_i     (tick),
    .cnt_o      (cnt_o),
    .csr_o      (csr_o),
    .irq_o      (irq_o),
    .wd_ovf_o   (wd_ovf),
    .pre_clr_o  (pre_clr),
    .por_req_o  (por_req),
    .mrst_req_o (mrst_req)
  );

  wdt_pulse_gen #(.LEN(PULSE_W)) u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (wd_ovf),
    .active_o (pin_act)
  );

  wdt_pulse_gen #(.LEN(RST_WIN)) u_por (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (por_req),
    .active_o (por_rst_o)
  );

  wdt_mrst_defer #(.RST_WIN(RST_WIN)) u_mrst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (mrst_req),
    .blocked_i (bus_busy_i || bus_rel_i || burst_i),
    .mrst_o    (mrst_o)
  );

  assign ovf_n_o = !pin_act;
endmodule

// File: rtl/wdt_rst_ctrl_chk.sv
module wdt_rst_ctrl_chk #(
  parameter int         CNT_W   = 8,
  parameter int         PULSE_W = 128,
  parameter int         RST_WIN = 512,
  parameter logic [7:0] KEY_CNT = 8'h5A
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [15:0]      wr_data_i,
  input logic             bus_busy_i,
  input logic             bus_rel_i,
  input logic             burst_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [7:0]       csr_o,
  input logic             ovf_n_o,
  input logic             por_rst_o,
  input logic             mrst_o
);
  int por_run, mrst_run, pin_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_run  <= 0;
      mrst_run <= 0;
      pin_run  <= 0;
    end else begin
      por_run  <= por_rst_o ? por_run + 1 : 0;
      mrst_run <= mrst_o ? mrst_run + 1 : 0;
      pin_run  <= !ovf_n_o ? pin_run + 1 : 0;
    end
  end

  AST_KEY_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[15:8] != KEY_CNT && !csr_o[5]) |=> $stable(cnt_o)); // R1

  AST_PIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_run <= PULSE_W); // R4

  AST_INTERVAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csr_o[6] && ovf_n_o && !por_rst_o) |=> (ovf_n_o && !por_rst_o)); // R5

  AST_POR_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_run <= RST_WIN); // R6

  AST_MRST_BUS_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mrst_o) |-> $past(!(bus_busy_i || bus_rel_i || burst_i))); // R7

  AST_MRST_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_run <= RST_WIN); // R7
endmodule

bind wdt_rst_ctrl wdt_rst_ctrl_chk #(
  .CNT_W(CNT_W), .PULSE_W(PULSE_W), .RST_WIN(RST_WIN), .KEY_CNT(KEY_CNT)
) u_chk (.*);

// File: tb/wdt_rst_ctrl_bench.sv
module wdt_rst_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int SHIFT_STEP = 1;
  localparam int PULSE_W    = 4;
  localparam int RST_WIN    = 16;
  localparam int N_VEC      = 8;
  // {sel, data[15:0], expected cnt[7:0], expected csr[7:0]}
  localparam logic [32:0] VEC [N_VEC] = '{
    {1'b0, 16'h5A07, 8'h07, 8'h00},
    {1'b0, 16'h3309, 8'h07, 8'h00},
    {1'b1, 16'hA543, 8'h07, 8'h43},
    {1'b1, 16'h0052, 8'h07, 8'h43},
    {1'b1, 16'h5A60, 8'h07, 8'h43},
    {1'b1, 16'hA5C1, 8'h07, 8'h41},
    {1'b0, 16'h5A1F, 8'h0F, 8'h41},
    {1'b1, 16'hA500, 8'h0F, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic busy = 1'b0, rel = 1'b0, burst = 1'b0;
  logic [CNT_W-1:0] cnt;
  logic [7:0] csr;
  logic irq, ovf_n, por, mrst;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_rst_ctrl #(.CNT_W(CNT_W), .SHIFT_STEP(SHIFT_STEP), .PULSE_W(PULSE_W),
                 .RST_WIN(RST_WIN)) u_wdt_rst_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .bus_busy_i(busy), .bus_rel_i(rel), .burst_i(burst),
    .cnt_o(cnt), .csr_o(csr), .irq_o(irq), .ovf_n_o(ovf_n),
    .por_rst_o(por), .mrst_o(mrst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // preset counter one step short of wrapping, then enable; returns after overflow edge
  task automatic arm(input logic [7:0] ctl);
    wr(1'b0, {8'h5A, 8'((1 << CNT_W) - 2)});
    wr(1'b1, {8'hA5, ctl});
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset cnt", int'(cnt), 0);
    chk("reset csr", int'(csr), 0);
    chk("reset pins", int'({irq, ovf_n, por, mrst}), 4'b0100);

    // R1 keyed write table
    for (int i = 0; i < N_VEC; i++) begin
      wr(VEC[i][32], VEC[i][31:16]);
      chk("R1 cnt", int'(cnt), int'(VEC[i][15:8]));
      chk("R1 csr", int'(csr), int'(VEC[i][7:0]));
    end

    // R5 interval overflow
    arm(8'h20);
    chk("R5 csr flag", int'(csr), 8'hA0);
    chk("R5 irq", int'(irq), 1);
    chk("R5 pin/resets", int'({ovf_n, por, mrst}), 3'b100);
    chk("R5 wrap", int'(cnt), 0);
    @(negedge clk);
    chk("R5 continue", int'(cnt), 1);
    wr(1'b1, 16'hA520);
    chk("R1 flag clear", int'(irq), 0);
    wr(1'b1, 16'hA500);

    // R3/R4 watchdog overflow without reset
    arm(8'h60);
    chk("R3 csr", int'(csr), 0);
    chk("R3 cnt", int'(cnt), 0);
    chk("R4 pin low", int'(ovf_n), 0);
    wait_n(PULSE_W - 1);
    chk("R4 pin still low", int'(ovf_n), 0);
    @(negedge clk);
    chk("R4 pin released", int'(ovf_n), 1);
    chk("R3 no reset", int'({por, mrst}), 0);

    // R2 prescaler ratio 2 after restart
    wr(1'b1, 16'hA521);
    wait_n(5);
    chk("R2 cnt@5", int'(cnt), 2);
    @(negedge clk);
    chk("R2 cnt@6", int'(cnt), 3);
    wr(1'b1, 16'hA500);
    wait_n(4);
    chk("R2 held", int'(cnt), 3);

    // R6 power-on type ignores bus
    busy = 1'b1;
    arm(8'h70);
    chk("R6 por on", int'(por), 1);
    chk("R9 csr", int'(csr), 8'hD0);
    chk("R9 cnt", int'(cnt), 0);
    wait_n(RST_WIN - 1);
    chk("R6 por last", int'(por), 1);
    @(negedge clk);
    chk("R6 por off", int'(por), 0);
    chk("R6 no manual", int'(mrst), 0);
    busy = 1'b0;

    // R7 manual type, bus free
    arm(8'h78);
    chk("R7 pend", int'(mrst), 0);
    @(negedge clk);
    chk("R7 mrst on", int'(mrst), 1);
    wait_n(RST_WIN - 1);
    chk("R7 mrst last", int'(mrst), 1);
    @(negedge clk);
    chk("R7 mrst off", int'(mrst), 0);
    chk("R7 no por", int'(por), 0);

    // R7 manual held by busy bus cycle
    busy = 1'b1;
    arm(8'h78);
    wait_n(5);
    chk("R7 busy hold", int'(mrst), 0);
    busy = 1'b0;
    @(negedge clk);
    chk("R7 after busy", int'(mrst), 1);
    wait_n(RST_WIN);

    // R8 burst for RST_WIN-1 cycles: still issued
    burst = 1'b1;
    arm(8'h78);
    wait_n(RST_WIN - 1);
    chk("R8 burst hold", int'(mrst), 0);
    burst = 1'b0;
    @(negedge clk);
    chk("R8 accepted", int'(mrst), 1);
    wait_n(RST_WIN);

    // R8 bus released for RST_WIN cycles: dropped
    rel = 1'b1;
    arm(8'h78);
    wait_n(RST_WIN);
    rel = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < RST_WIN + 2; k++) begin
        @(negedge clk);
        if (mrst) seen++;
      end
      chk("R8 dropped", seen, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule